// File: doc/BRIEF.md
# Standby and Deep-Standby Power Sequencer

This block decides which power mode a small controller-style system is in and drives the enables that put the mode into effect. A one-cycle sleep request is read together with a standby enable and a deep-standby enable. With both enables clear the request only halts the clock. With standby enabled the system enters software standby: the oscillator stops, and the power domains and I/O state are kept. If deep standby is also enabled and no wake source is active, the block drops on to deep standby one cycle later. In deep standby the core, peripheral and oscillator supplies are removed. RAM supply stays on or is cut according to a 3-bit cut field.

Seventeen wake lines feed the sequencer: one non-maskable line and sixteen maskable request lines. Each line passes through its own two-flop synchronizer. A wake from software standby starts an oscillator settling period whose length comes from a 5-bit select. When that period ends, the block returns to run and raises a one-cycle wake-interrupt pulse. A wake from deep standby is handled like a reset. Power comes back first, then the oscillator, then the settling period runs. At the end a sticky flag records that deep standby was left, and no interrupt pulse is issued.

All pins are plain control and status levels. No data stream passes through the block, so none of its pins use a valid/ready handshake.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in run: clk_halt=0, osc_en=1, dom_pwr_en=1, ram_pwr_en=1, io_hold=0, wake_irq=0 and deep_exit_flag=0.
- R2: A sleep request with stby_en=0 sets only clk_halt (osc_en, dom_pwr_en and ram_pwr_en stay 1, io_hold stays 0). Any synchronized wake returns the block to run with no wake_irq pulse.
- R3: A sleep request with stby_en=1 and deep_en=0 enters software standby: clk_halt=1, osc_en=0, dom_pwr_en=1, ram_pwr_en=1, io_hold=1. The block stays there until a wake arrives.
- R4: A wake in software standby starts a settling period of N=2^(4+settle_sel) cycles with osc_en=1 and io_hold=1. The block then returns to run and asserts wake_irq for exactly one cycle. For a wake driven in the cycle after edge c, the pulse is seen after edge c+N+3.
- R5: With stby_en=1, deep_en=1 and no active wake, deep standby follows one cycle after standby entry: clk_halt=1, osc_en=0, dom_pwr_en=0, io_hold=1.
- R6: The RAM cut field is sampled when deep standby is entered. A value of 3'b000 keeps ram_pwr_en=1 in deep standby. A value of 3'b111, or any other value, gives ram_pwr_en=0.
- R7: A wake that is active in the cycle the block sits in software standby takes priority over deep_en. The block goes straight to settling (dom_pwr_en stays 1) and ends with a wake_irq pulse.
- R8: A wake in deep standby first gives one cycle with dom_pwr_en=1, ram_pwr_en=1 and osc_en=0. Settling then continues with osc_en=1, for N cycles in total counted from the power-on cycle. The block then returns to run with deep_exit_flag=1 and no wake_irq pulse. The flag clears when the next sleep request is accepted.
- R9: settle_sel values above the SEL_CAP parameter saturate at SEL_CAP (default 15).
- R10: Each wake source acts as a wake: nmi_in and every bit of irq_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle sleep request, read in run |
| stby_en | input | 1 | Selects software standby on sleep |
| deep_en | input | 1 | Allows the drop to deep standby |
| settle_sel | input | 5 | Settling length select, N=2^(4+sel) |
| ram_cut | input | 3 | RAM supply cut field for deep standby |
| nmi_in | input | 1 | Non-maskable wake line, asynchronous |
| irq_in | input | 16 | Maskable wake lines, asynchronous |
| clk_halt | output | 1 | Clock stopped to core |
| osc_en | output | 1 | Oscillator enable |
| dom_pwr_en | output | 1 | Core and peripheral supply enable |
| ram_pwr_en | output | 1 | RAM supply enable |
| io_hold | output | 1 | Freeze I/O pin state |
| wake_irq | output | 1 | One-cycle wake interrupt after settling |
| deep_exit_flag | output | 1 | Sticky: last wake was out of deep standby |

## Verification
A mode change caused by a sleep request is visible one edge after the request cycle. The drop to deep standby shows up one edge after that. A wake line needs two edges to pass its synchronizer, and a third edge changes the mode. The wake pulse, or the deep-exit flag, therefore appears N+3 edges after the cycle in which the line was driven. The bench records the cycle count at each drive, places the expected pulse cycle in a scoreboard queue, and samples levels on falling edges at exactly those computed offsets. A pulse that comes early or late, or that is not expected at all, is reported.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    PM_RUN,
    PM_NAP,
    PM_STBY,
    PM_DEEP,
    PM_REPOWER,
    PM_SETTLE
  } pm_state_e;

  typedef struct packed {
    logic halt;
    logic osc;
    logic dom;
    logic ram;
    logic hold;
  } pm_rails_t;
endpackage

// File: rtl/pm_wake_sync.sv
module pm_wake_sync #(
  parameter int N_SRC = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  output logic             any_o
);
  logic [N_SRC-1:0] synced;

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    logic [1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[0], src_i[i]};
    end
    assign synced[i] = sh[1];
  end

  assign any_o = |synced;
endmodule

// File: rtl/pm_settle_timer.sv
module pm_settle_timer #(
  parameter int SEL_W     = 5,
  parameter int BASE_LOG2 = 4,
  parameter int SEL_CAP   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             done_o
);
  localparam int CNT_W = BASE_LOG2 + SEL_CAP;
  localparam logic [SEL_W-1:0] CAP_V = SEL_W'(SEL_CAP);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;
  logic [SEL_W-1:0] sel_eff;

  always_comb begin
    sel_eff = (sel_i > CAP_V) ? CAP_V : sel_i;
    limit   = (CNT_W'(1) << (BASE_LOG2 + int'(sel_eff))) - CNT_W'(1);
  end

  assign done_o = run_i && (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (start_i)          count <= '0;
    else if (run_i && !done_o) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ     = 16,
  parameter int SEL_W     = 5,
  parameter int CUT_W     = 3,
  parameter int BASE_LOG2 = 4,
  parameter int SEL_CAP   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             stby_en,
  input  logic             deep_en,
  input  logic [SEL_W-1:0] settle_sel,
  input  logic [CUT_W-1:0] ram_cut,
  input  logic             nmi_in,
  input  logic [N_IRQ-1:0] irq_in,
  output logic             clk_halt,
  output logic             osc_en,
  output logic             dom_pwr_en,
  output logic             ram_pwr_en,
  output logic             io_hold,
  output logic             wake_irq,
  output logic             deep_exit_flag
);
  localparam int N_SRC = N_IRQ + 1;

  pm_state_e state, nxt;
  pm_rails_t rails;
  logic      wake_any, settle_done, settle_start, settle_run;
  logic      keep_ram, from_deep;

  pm_wake_sync #(.N_SRC(N_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i ({nmi_in, irq_in}),
    .any_o (wake_any)
  );

  assign settle_start = ((state == PM_STBY) || (state == PM_DEEP)) && wake_any;
  assign settle_run   = (state == PM_REPOWER) || (state == PM_SETTLE);

  pm_settle_timer #(
    .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .SEL_CAP(SEL_CAP)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (settle_start),
    .run_i   (settle_run),
    .sel_i   (settle_sel),
    .done_o  (settle_done)
  );

  always_comb begin
    nxt = state;
    case (state)
      PM_RUN:     if (sleep_req) nxt = stby_en ? PM_STBY : PM_NAP;
      PM_NAP:     if (wake_any) nxt = PM_RUN;
      PM_STBY:    if (wake_any) nxt = PM_SETTLE;
                  else if (deep_en) nxt = PM_DEEP;
      PM_DEEP:    if (wake_any) nxt = PM_REPOWER;
      PM_REPOWER: nxt = PM_SETTLE;
      PM_SETTLE:  if (settle_done) nxt = PM_RUN;
      default:    nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= PM_RUN;
      keep_ram       <= 1'b1;
      from_deep      <= 1'b0;
      wake_irq       <= 1'b0;
      deep_exit_flag <= 1'b0;
    end else begin
      state    <= nxt;
      wake_irq <= (state == PM_SETTLE) && settle_done && !from_deep;
      if ((state == PM_STBY) && (nxt == PM_DEEP))
        keep_ram <= (ram_cut == '0);
      if ((state == PM_DEEP) && wake_any)
        from_deep <= 1'b1;
      else if ((state == PM_SETTLE) && settle_done)
        from_deep <= 1'b0;
      if ((state == PM_SETTLE) && settle_done && from_deep)
        deep_exit_flag <= 1'b1;
      else if ((state == PM_RUN) && sleep_req)
        deep_exit_flag <= 1'b0;
    end
  end

  always_comb begin
    case (state)
      PM_NAP:     rails = '{halt: 1'b1, osc: 1'b1, dom: 1'b1, ram: 1'b1,     hold: 1'b0};
      PM_STBY:    rails = '{halt: 1'b1, osc: 1'b0, dom: 1'b1, ram: 1'b1,     hold: 1'b1};
      PM_DEEP:    rails = '{halt: 1'b1, osc: 1'b0, dom: 1'b0, ram: keep_ram, hold: 1'b1};
      PM_REPOWER: rails = '{halt: 1'b1, osc: 1'b0, dom: 1'b1, ram: 1'b1,     hold: 1'b1};
      PM_SETTLE:  rails = '{halt: 1'b1, osc: 1'b1, dom: 1'b1, ram: 1'b1,     hold: 1'b1};
      default:    rails = '{halt: 1'b0, osc: 1'b1, dom: 1'b1, ram: 1'b1,     hold: 1'b0};
    endcase
  end

  assign clk_halt   = rails.halt;
  assign osc_en     = rails.osc;
  assign dom_pwr_en = rails.dom;
  assign ram_pwr_en = rails.ram;
  assign io_hold    = rails.hold;
endmodule

// File: rtl/pm_seq_chk.sv
module pm_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_halt,
  input logic osc_en,
  input logic dom_pwr_en,
  input logic ram_pwr_en,
  input logic io_hold,
  input logic wake_irq,
  input logic deep_exit_flag
);
  assert_nap_rails_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_halt && !io_hold) |-> (osc_en && dom_pwr_en && ram_pwr_en));

  assert_hold_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    io_hold |-> clk_halt);

  assert_pulse_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (!clk_halt && osc_en && !io_hold));

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);

  assert_deep_rails_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_pwr_en |-> (clk_halt && !osc_en && io_hold));

  assert_ram_only_deep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_pwr_en |-> !dom_pwr_en);

  assert_power_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_pwr_en) |-> !osc_en);

  assert_flag_on_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deep_exit_flag) |-> (!clk_halt && !wake_irq));
endmodule

bind pwr_mode_seq pm_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .clk_halt       (clk_halt),
  .osc_en         (osc_en),
  .dom_pwr_en     (dom_pwr_en),
  .ram_pwr_en     (ram_pwr_en),
  .io_hold        (io_hold),
  .wake_irq       (wake_irq),
  .deep_exit_flag (deep_exit_flag)
);

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_req = 1'b0, stby_en = 1'b0, deep_en = 1'b0;
  logic [4:0]  settle_sel = '0;
  logic [2:0]  ram_cut = '0;
  logic        nmi_in = 1'b0;
  logic [15:0] irq_in = '0;
  logic        clk_halt, osc_en, dom_pwr_en, ram_pwr_en, io_hold, wake_irq, deep_exit_flag;

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_mode_seq #(.SEL_CAP(3)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_en(stby_en),
    .deep_en(deep_en), .settle_sel(settle_sel), .ram_cut(ram_cut),
    .nmi_in(nmi_in), .irq_in(irq_in), .clk_halt(clk_halt), .osc_en(osc_en),
    .dom_pwr_en(dom_pwr_en), .ram_pwr_en(ram_pwr_en), .io_hold(io_hold),
    .wake_irq(wake_irq), .deep_exit_flag(deep_exit_flag)
  );

  // Monitor: compares wake pulses against the scoreboard queue (R4, R2, R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (wake_irq) begin
        vectors++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) void'(exp_q.pop_front());
        else begin
          fails++;
          $display("FAIL R4 wake pulse at cycle %0d: got 1 expected 0", cyc);
        end
      end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
        vectors++; fails++;
        $display("FAIL R4 missing wake pulse: got none expected cycle %0d", exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic check_rails(input string tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {clk_halt, osc_en, dom_pwr_en, ram_pwr_en, io_hold};
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s rails: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic sleep_pulse(output int c);
    @(negedge clk);
    sleep_req = 1'b1;
    c = cyc;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  // src < 0 selects the non-maskable line
  task automatic wake_pulse(input int src, input int n, input bit expect_irq, output int c);
    @(negedge clk);
    if (src < 0) nmi_in = 1'b1; else irq_in[src] = 1'b1;
    c = cyc;
    if (expect_irq) exp_q.push_back(c + n + 3);
    @(negedge clk);
    nmi_in = 1'b0;
    irq_in = '0;
  endtask

  localparam logic [4:0] RUN_V = 5'b01110, NAP_V = 5'b11110, STBY_V = 5'b10111,
                         SETL_V = 5'b11111, DEEPK_V = 5'b10011, DEEPC_V = 5'b10001;

  initial begin
    int c, c2;
    step(3);
    rst_n = 1'b1;
    step(1);
    check_rails("R1 reset", RUN_V);
    check_bit("R1 wake_irq", wake_irq, 1'b0);
    check_bit("R1 deep_exit_flag", deep_exit_flag, 1'b0);

    // R2: plain sleep
    stby_en = 1'b0;
    sleep_pulse(c);
    check_rails("R2 nap", NAP_V);
    wake_pulse(5, 0, 1'b0, c2);
    wait_to(c2 + 3);
    check_rails("R2 back to run", RUN_V);
    step(20);

    // R3/R4: software standby, nmi wake, N=16
    stby_en = 1'b1; deep_en = 1'b0; settle_sel = 5'd0;
    sleep_pulse(c);
    check_rails("R3 standby", STBY_V);
    step(10);
    check_rails("R3 standby held", STBY_V);
    wake_pulse(-1, 16, 1'b1, c2);
    wait_to(c2 + 3);
    check_rails("R4 settling", SETL_V);
    wait_to(c2 + 19);
    check_rails("R4 run after settle", RUN_V);
    step(2);

    // R10/R4: irq line 12, N=64
    settle_sel = 5'd2;
    sleep_pulse(c);
    wake_pulse(12, 64, 1'b1, c2);
    wait_to(c2 + 66);
    check_rails("R4 still settling N=64", SETL_V);
    wait_to(c2 + 67);
    check_rails("R10 irq12 wake run", RUN_V);
    step(2);

    // R5/R6/R8: deep standby keeping RAM, N=32
    deep_en = 1'b1; ram_cut = 3'b000; settle_sel = 5'd1;
    sleep_pulse(c);
    wait_to(c + 2);
    check_rails("R5 R6 deep ram kept", DEEPK_V);
    step(5);
    check_rails("R5 deep held", DEEPK_V);
    wake_pulse(0, 32, 1'b0, c2);
    wait_to(c2 + 3);
    check_rails("R8 power before osc", STBY_V);
    wait_to(c2 + 4);
    check_rails("R8 osc on", SETL_V);
    check_bit("R8 flag during settle", deep_exit_flag, 1'b0);
    wait_to(c2 + 34);
    check_rails("R8 settle length", SETL_V);
    wait_to(c2 + 35);
    check_rails("R8 run after deep", RUN_V);
    check_bit("R8 deep_exit_flag set", deep_exit_flag, 1'b1);
    step(3);

    // R6: all ones cuts RAM; R8 flag clears on accepted sleep
    ram_cut = 3'b111;
    sleep_pulse(c);
    check_bit("R8 flag cleared on sleep", deep_exit_flag, 1'b0);
    wait_to(c + 2);
    check_rails("R6 deep ram cut 111", DEEPC_V);
    wake_pulse(-1, 32, 1'b0, c2);
    wait_to(c2 + 35);
    check_bit("R8 flag after nmi deep wake", deep_exit_flag, 1'b1);

    // R6: mixed value behaves as all ones
    ram_cut = 3'b010;
    sleep_pulse(c);
    wait_to(c + 2);
    check_rails("R6 deep ram cut 010", DEEPC_V);
    wake_pulse(7, 32, 1'b0, c2);
    wait_to(c2 + 35);
    check_rails("R10 irq7 deep wake run", RUN_V);
    step(2);

    // R7: wake active at entry aborts deep, N=16
    settle_sel = 5'd0; ram_cut = 3'b111;
    @(negedge clk);
    irq_in[15] = 1'b1;
    step(3);
    sleep_pulse(c);
    exp_q.push_back(c + 18);
    check_rails("R7 standby entry", STBY_V);
    wait_to(c + 2);
    check_rails("R7 settle not deep", SETL_V);
    irq_in = '0;
    wait_to(c + 18);
    check_rails("R7 run", RUN_V);
    check_bit("R7 no deep exit flag", deep_exit_flag, 1'b0);
    step(2);

    // R9: sel 20 saturates at cap 3 -> N=128
    deep_en = 1'b0; settle_sel = 5'd20;
    sleep_pulse(c);
    wake_pulse(3, 128, 1'b1, c2);
    wait_to(c2 + 130);
    check_rails("R9 saturated still settling", SETL_V);
    wait_to(c2 + 131);
    check_rails("R9 saturated run", RUN_V);

    step(5);
    if (exp_q.size() != 0) begin
      vectors++; fails++;
      $display("FAIL R4 pending pulses: got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule